// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block produces the digital drive clocks for a three-colour linear CCD image sensor from a fast system clock. The clocks are a transfer-gate pulse shared by all three colour rows, a complementary pair of main shift-register clocks, a pair of last-stage register clocks that follow the same pattern, and a narrow reset-gate pulse at the start of every pixel period. The analog level shifters, output amplifiers and the converter that follows are outside the block.

A line starts on a one-cycle start strobe. First comes a setup guard in which the shift clocks are frozen. The transfer pulse follows, which moves charge from the photocells into the registers. A hold guard with the clocks still frozen comes next, and then a fixed number of pixel periods is clocked out. Every duration is a run-time count of system-clock ticks. For downstream sampling, the block also gives a pixel index, a two-bit region tag and a sample strobe placed a programmable delay after each reset pulse falls. In continuous mode the next line starts by itself after a programmable integration gap.

The line is made of four regions, each with a parameter count. It opens with dummy and optical-black pixels, then a short invalid group, then the valid pixels, and ends with a trailing invalid group. The defaults are 64, 3, 2700 and 2, which gives 2769 pixel periods per line.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted and after it is released, every output stays at its idle level until a line starts: transfer gate 0, phase-1 clocks (main and last-stage) 1, phase-2 clocks 0, reset gate 0, sample strobe 0, busy 0, pixel index 0 and region tag 2'b00. A reset in the middle of a line returns all outputs to these levels.
- R2: A start strobe seen while idle begins a line. The line runs `cfgSetup` ticks with the clocks frozen at idle levels, then `cfgXfer` ticks with the transfer gate high, then `cfgHold` ticks frozen, and then pixel periods follow. The phase-1 clocks are high, and the phase-2 clocks and reset gate are low, for the whole time the transfer gate is high.
- R3: During pixel period n, phase 1 (main and last-stage) is 1 when n is even and 0 when n is odd. Phase 2 (main and last-stage) is always the complement of phase 1.
- R4: The reset gate is high during the first `cfgRstWidth` ticks of each pixel period and low during the rest of it. It is low outside the pixel phase.
- R5: The sample strobe is high for exactly one tick in each pixel period, at tick offset `cfgRstWidth + cfgSampleDly`, counted from 0. This includes the last tick of the period, and the strobe is never high while the reset gate is high.
- R6: The pixel index runs from 0 to the total count minus 1 and holds each value for `cfgPixPer` ticks. It is 0 outside the pixel phase.
- R7: The region tag is 2'b00 for the dummy and black pixels, 2'b10 for the leading invalid group, 2'b01 for the valid pixels and 2'b10 for the trailing invalid group.
- R8: Busy is high from the first transfer-gate tick to the last tick of the last pixel period, and low otherwise.
- R9: In single mode the block returns to idle after the last pixel. A start strobe given while a line is running has no effect on any output.
- R10: When continuous mode is set at the last pixel tick, the block waits `cfgGap` ticks with idle outputs and then begins the next line's setup guard without a new start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lineStart | input | 1 | Start-of-line strobe |
| contMode | input | 1 | Continuous line mode |
| cfgSetup | input | CNT_W | Freeze ticks before the transfer pulse (at least 1) |
| cfgXfer | input | CNT_W | Transfer pulse width in ticks (at least 1) |
| cfgHold | input | CNT_W | Freeze ticks after the transfer pulse (at least 1) |
| cfgPixPer | input | CNT_W | Pixel period in ticks (at least 2) |
| cfgRstWidth | input | CNT_W | Reset pulse width in ticks |
| cfgSampleDly | input | CNT_W | Sample strobe delay after the reset pulse falls |
| cfgGap | input | CNT_W | Integration gap in continuous mode (at least 1) |
| tgOut | output | 1 | Transfer-gate pulse |
| phi1Out | output | 1 | Main shift clock, phase 1 |
| phi2Out | output | 1 | Main shift clock, phase 2 |
| phiL1Out | output | 1 | Last-stage clock, phase 1 |
| phiL2Out | output | 1 | Last-stage clock, phase 2 |
| rstGateOut | output | 1 | Per-pixel reset-gate pulse |
| sampleStb | output | 1 | Downstream sample strobe |
| busy | output | 1 | Line in progress |
| pixIndex | output | PIX_W | Current pixel index |
| regionTag | output | 2 | Region code of the current pixel |

## Verification
Lines are run under three timing sets. The first has a long transfer pulse, a six-tick pixel and the strobe in the middle of the period. The second uses the shortest guards with a four-tick pixel and a zero-delay strobe, which tells an off-by-one in the strobe offset apart from a correct one. The third places the strobe on the last tick of the period. A short-geometry line crosses every region boundary, so a misplaced boundary shows up in the tag at a single index. A start strobe is also injected mid-line, continuous mode is switched off during the second of two chained lines to separate the gap path from the idle path, and a reset is applied in the middle of a line.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_PIX,
    ST_GAP
  } lineState_t;

  // strobes from the line control to the pixel datapath
  typedef struct packed {
    logic xferOn;
    logic pixRun;
  } ctrlStrobe_t;

  localparam logic [1:0] RGN_BLACK   = 2'b00;
  localparam logic [1:0] RGN_VALID   = 2'b01;
  localparam logic [1:0] RGN_INVALID = 2'b10;

endpackage

// File: rtl/ccd_line_ctrl.sv
module ccd_line_ctrl
  import ccd_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineStart,
  input  logic             contMode,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgXfer,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgGap,
  input  logic             lineDone,
  output ctrlStrobe_t      strobe,
  output logic             busy
);

  lineState_t       state;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limit;
  logic             phaseEnd;

  always_comb begin
    case (state)
      ST_SETUP: limit = cfgSetup;
      ST_XFER:  limit = cfgXfer;
      ST_HOLD:  limit = cfgHold;
      ST_GAP:   limit = cfgGap;
      default:  limit = {{(CNT_W-1){1'b0}}, 1'b1};
    endcase
  end

  assign phaseEnd = (tickCnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (lineStart) state <= ST_SETUP;
        end
        ST_SETUP, ST_XFER, ST_HOLD, ST_GAP: begin
          if (phaseEnd) begin
            tickCnt <= '0;
            case (state)
              ST_SETUP: state <= ST_XFER;
              ST_XFER:  state <= ST_HOLD;
              ST_HOLD:  state <= ST_PIX;
              default:  state <= ST_SETUP;
            endcase
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PIX: begin
          tickCnt <= '0;
          if (lineDone) state <= contMode ? ST_GAP : ST_IDLE;
        end
        default: begin
          state   <= ST_IDLE;
          tickCnt <= '0;
        end
      endcase
    end
  end

  assign strobe.xferOn = (state == ST_XFER);
  assign strobe.pixRun = (state == ST_PIX);
  assign busy = (state == ST_XFER) || (state == ST_HOLD) || (state == ST_PIX);

  // R9: a finished line without continuous mode lands in idle
  a_r9_single_to_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_PIX && state != ST_PIX && !$past(contMode)) |-> state == ST_IDLE);

  // R10: the integration gap always leads into a new setup guard
  a_r10_gap_to_setup: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_GAP && state != ST_GAP) |-> state == ST_SETUP);

endmodule

// File: rtl/ccd_pix_dp.sv
module ccd_pix_dp
  import ccd_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BLACK_PIX = 64,
  parameter int INV_LEAD  = 3,
  parameter int VALID_PIX = 2700,
  parameter int INV_TAIL  = 2,
  parameter int PIX_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] cfgPixPer,
  input  logic [CNT_W-1:0] cfgRstWidth,
  input  logic [CNT_W-1:0] cfgSampleDly,
  output logic             lineDone,
  output logic             tgOut,
  output logic             phi1Out,
  output logic             phi2Out,
  output logic             phiL1Out,
  output logic             phiL2Out,
  output logic             rstGateOut,
  output logic             sampleStb,
  output logic [PIX_W-1:0] pixIndex,
  output logic [1:0]       regionTag
);

  localparam int LEAD_END_I  = BLACK_PIX + INV_LEAD;
  localparam int VALID_END_I = LEAD_END_I + VALID_PIX;
  localparam int TOTAL_I     = VALID_END_I + INV_TAIL;

  localparam logic [PIX_W-1:0] BLACK_END = PIX_W'(BLACK_PIX);
  localparam logic [PIX_W-1:0] LEAD_END  = PIX_W'(LEAD_END_I);
  localparam logic [PIX_W-1:0] VALID_END = PIX_W'(VALID_END_I);
  localparam logic [PIX_W-1:0] LAST_IDX  = PIX_W'(TOTAL_I - 1);

  logic [CNT_W-1:0] pixTick;
  logic [PIX_W-1:0] pixIdx;
  logic             periodEnd;
  logic [CNT_W:0]   sampleAt;
  logic             phaseA;

  assign periodEnd = strobe.pixRun && (pixTick == cfgPixPer - 1'b1);
  assign lineDone  = periodEnd && (pixIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || !strobe.pixRun || lineDone) begin
      pixTick <= '0;
      pixIdx  <= '0;
    end else if (periodEnd) begin
      pixTick <= '0;
      pixIdx  <= pixIdx + 1'b1;
    end else begin
      pixTick <= pixTick + 1'b1;
    end
  end

  assign sampleAt = {1'b0, cfgRstWidth} + {1'b0, cfgSampleDly};

  // phase 1 frozen high outside the pixel phase, alternating per pixel inside it
  assign phaseA     = strobe.pixRun ? ~pixIdx[0] : 1'b1;
  assign tgOut      = strobe.xferOn;
  assign phi1Out    = phaseA;
  assign phi2Out    = ~phaseA;
  assign phiL1Out   = phaseA;
  assign phiL2Out   = ~phaseA;
  assign rstGateOut = strobe.pixRun && (pixTick < cfgRstWidth);
  assign sampleStb  = strobe.pixRun && ({1'b0, pixTick} == sampleAt);
  assign pixIndex   = pixIdx;

  always_comb begin
    if (pixIdx < BLACK_END)      regionTag = RGN_BLACK;
    else if (pixIdx < LEAD_END)  regionTag = RGN_INVALID;
    else if (pixIdx < VALID_END) regionTag = RGN_VALID;
    else                         regionTag = RGN_INVALID;
  end

  // R6: the index only ever steps up by one or returns to zero
  a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
    (pixIdx != $past(pixIdx) && pixIdx != '0) |-> pixIdx == $past(pixIdx) + 1'b1);

  // R5: the sample strobe never overlaps the reset pulse
  a_r5_strobe_clear_of_reset: assert property (@(posedge clk) disable iff (rst)
    sampleStb |-> !rstGateOut);

  // R4: reset pulses occur only in the pixel phase
  a_r4_reset_in_pixels: assert property (@(posedge clk) disable iff (rst)
    rstGateOut |-> !tgOut);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BLACK_PIX = 64,
  parameter int INV_LEAD  = 3,
  parameter int VALID_PIX = 2700,
  parameter int INV_TAIL  = 2,
  parameter int PIX_W     = $clog2(BLACK_PIX + INV_LEAD + VALID_PIX + INV_TAIL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineStart,
  input  logic             contMode,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgXfer,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgPixPer,
  input  logic [CNT_W-1:0] cfgRstWidth,
  input  logic [CNT_W-1:0] cfgSampleDly,
  input  logic [CNT_W-1:0] cfgGap,
  output logic             tgOut,
  output logic             phi1Out,
  output logic             phi2Out,
  output logic             phiL1Out,
  output logic             phiL2Out,
  output logic             rstGateOut,
  output logic             sampleStb,
  output logic             busy,
  output logic [PIX_W-1:0] pixIndex,
  output logic [1:0]       regionTag
);

  ctrlStrobe_t strobe;
  logic        lineDone;

  ccd_line_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lineStart(lineStart),
    .contMode (contMode),
    .cfgSetup (cfgSetup),
    .cfgXfer  (cfgXfer),
    .cfgHold  (cfgHold),
    .cfgGap   (cfgGap),
    .lineDone (lineDone),
    .strobe   (strobe),
    .busy     (busy)
  );

  ccd_pix_dp #(
    .CNT_W    (CNT_W),
    .BLACK_PIX(BLACK_PIX),
    .INV_LEAD (INV_LEAD),
    .VALID_PIX(VALID_PIX),
    .INV_TAIL (INV_TAIL),
    .PIX_W    (PIX_W)
  ) i_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .cfgPixPer   (cfgPixPer),
    .cfgRstWidth (cfgRstWidth),
    .cfgSampleDly(cfgSampleDly),
    .lineDone    (lineDone),
    .tgOut       (tgOut),
    .phi1Out     (phi1Out),
    .phi2Out     (phi2Out),
    .phiL1Out    (phiL1Out),
    .phiL2Out    (phiL2Out),
    .rstGateOut  (rstGateOut),
    .sampleStb   (sampleStb),
    .pixIndex    (pixIndex),
    .regionTag   (regionTag)
  );

  // R2: the transfer pulse sits inside frozen shift clocks with no reset pulse
  a_r2_tg_in_frozen_window: assert property (@(posedge clk) disable iff (rst)
    tgOut |-> (phi1Out && !phi2Out && phiL1Out && !phiL2Out && !rstGateOut));

  // R8: busy covers every transfer tick
  a_r8_busy_over_tg: assert property (@(posedge clk) disable iff (rst)
    tgOut |-> busy);

endmodule

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;

  localparam int CW    = 16;
  localparam int NBLK  = 3;
  localparam int NLEAD = 2;
  localparam int NVAL  = 6;
  localparam int NTAIL = 2;
  localparam int NTOT  = NBLK + NLEAD + NVAL + NTAIL;
  localparam int PW    = $clog2(NTOT);

  typedef struct {
    bit       tg, p1, p2, rg, smp, bsy;
    int       idx;
    bit [1:0] rgn;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineStart = 1'b0;
  logic contMode = 1'b0;
  logic [CW-1:0] cfgSetup = 16'd3, cfgXfer = 16'd5, cfgHold = 16'd3;
  logic [CW-1:0] cfgPixPer = 16'd6, cfgRstWidth = 16'd2, cfgSampleDly = 16'd1;
  logic [CW-1:0] cfgGap = 16'd4;
  logic tgOut, phi1Out, phi2Out, phiL1Out, phiL2Out, rstGateOut, sampleStb, busy;
  logic [PW-1:0] pixIndex;
  logic [1:0] regionTag;

  int checks = 0;
  int failures = 0;
  string scen = "reset";
  exp_t q[$];

  always #4 clk = ~clk;

  ccd_line_timer #(
    .CNT_W(CW), .BLACK_PIX(NBLK), .INV_LEAD(NLEAD), .VALID_PIX(NVAL), .INV_TAIL(NTAIL)
  ) i_ccd_line_timer (
    .clk(clk), .rst(rst), .lineStart(lineStart), .contMode(contMode),
    .cfgSetup(cfgSetup), .cfgXfer(cfgXfer), .cfgHold(cfgHold), .cfgPixPer(cfgPixPer),
    .cfgRstWidth(cfgRstWidth), .cfgSampleDly(cfgSampleDly), .cfgGap(cfgGap),
    .tgOut(tgOut), .phi1Out(phi1Out), .phi2Out(phi2Out), .phiL1Out(phiL1Out),
    .phiL2Out(phiL2Out), .rstGateOut(rstGateOut), .sampleStb(sampleStb), .busy(busy),
    .pixIndex(pixIndex), .regionTag(regionTag)
  );

  task automatic chk(input int act, input int expv, input string req, input string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s [%s] %s actual %0d expected %0d at %0t", req, scen, what, act, expv, $time);
    end
  endtask

  // R7: region boundaries from the requirement
  function automatic bit [1:0] regionOf(input int n);
    if (n < NBLK) return 2'b00;
    if (n < NBLK + NLEAD) return 2'b10;
    if (n < NBLK + NLEAD + NVAL) return 2'b01;
    return 2'b10;
  endfunction

  task automatic pushIdle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.tg = 0; e.p1 = 1; e.p2 = 0; e.rg = 0; e.smp = 0; e.bsy = 0; e.idx = 0; e.rgn = 2'b00;
      q.push_back(e);
    end
  endtask

  task automatic pushFrozen(input int n, input bit tgv);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.tg = tgv; e.p1 = 1; e.p2 = 0; e.rg = 0; e.smp = 0; e.bsy = 1; e.idx = 0; e.rgn = 2'b00;
      q.push_back(e);
    end
  endtask

  task automatic pushLine();
    pushIdle(int'(cfgSetup));
    pushFrozen(int'(cfgXfer), 1'b1);
    pushFrozen(int'(cfgHold), 1'b0);
    for (int n = 0; n < NTOT; n++) begin
      for (int t = 0; t < int'(cfgPixPer); t++) begin
        exp_t e;
        e.tg = 0; e.p1 = (n % 2 == 0); e.p2 = !e.p1;
        e.rg = (t < int'(cfgRstWidth));
        e.smp = (t == int'(cfgRstWidth) + int'(cfgSampleDly));
        e.bsy = 1; e.idx = n; e.rgn = regionOf(n);
        q.push_back(e);
      end
    end
  endtask

  // monitor: pop one expected item per cycle and compare
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(int'(tgOut), int'(e.tg), "R2", "tgOut");
        chk(int'(phi1Out), int'(e.p1), "R3", "phi1Out");
        chk(int'(phi2Out), int'(e.p2), "R3", "phi2Out");
        chk(int'(phiL1Out), int'(e.p1), "R3", "phiL1Out");
        chk(int'(phiL2Out), int'(e.p2), "R3", "phiL2Out");
        chk(int'(rstGateOut), int'(e.rg), "R4", "rstGateOut");
        chk(int'(sampleStb), int'(e.smp), "R5", "sampleStb");
        chk(int'(pixIndex), e.idx, "R6", "pixIndex");
        chk(int'(regionTag), int'(e.rgn), "R7", "regionTag");
        chk(int'(busy), int'(e.bsy), "R8", "busy");
      end
    end
  end

  task automatic checkIdle(input string req);
    chk(int'(tgOut), 0, req, "tgOut idle");
    chk(int'(phi1Out), 1, req, "phi1Out idle");
    chk(int'(phi2Out), 0, req, "phi2Out idle");
    chk(int'(phiL1Out), 1, req, "phiL1Out idle");
    chk(int'(phiL2Out), 0, req, "phiL2Out idle");
    chk(int'(rstGateOut), 0, req, "rstGateOut idle");
    chk(int'(sampleStb), 0, req, "sampleStb idle");
    chk(int'(busy), 0, req, "busy idle");
    chk(int'(pixIndex), 0, req, "pixIndex idle");
    chk(int'(regionTag), 0, req, "regionTag idle");
  endtask

  // driver: push the expected items for a single line, then strobe start
  task automatic runSingle(input string name, input int pokeAt);
    wait (q.size() == 0);
    @(negedge clk);
    scen = name;
    pushLine();
    pushIdle(5);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    if (pokeAt > 0) begin
      // R9: a start strobe mid-line must change nothing
      repeat (pokeAt) @(negedge clk);
      lineStart = 1'b1;
      @(negedge clk);
      lineStart = 1'b0;
    end
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkIdle("R1");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1");
    pushIdle(3);

    runSingle("R2 set A", 0);

    cfgSetup = 16'd1; cfgXfer = 16'd2; cfgHold = 16'd1;
    cfgPixPer = 16'd4; cfgRstWidth = 16'd1; cfgSampleDly = 16'd0;
    runSingle("R5 set B zero delay", 0);

    cfgSetup = 16'd2; cfgXfer = 16'd4; cfgHold = 16'd2;
    cfgPixPer = 16'd6; cfgRstWidth = 16'd2; cfgSampleDly = 16'd3;
    runSingle("R5 strobe on last tick", 0);

    cfgSetup = 16'd3; cfgXfer = 16'd5; cfgHold = 16'd3;
    cfgPixPer = 16'd6; cfgRstWidth = 16'd2; cfgSampleDly = 16'd1;
    runSingle("R9 start ignored", 40);

    // R10: two chained lines, continuous mode dropped during the second
    wait (q.size() == 0);
    @(negedge clk);
    scen = "R10 continuous";
    contMode = 1'b1;
    pushLine();
    pushIdle(int'(cfgGap));
    pushLine();
    pushIdle(5);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    repeat (110) @(negedge clk);
    contMode = 1'b0;
    wait (q.size() == 0);

    // R1: reset in the middle of a line
    @(negedge clk);
    scen = "R1 mid-line reset";
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    repeat (30) @(negedge clk);
    chk(int'(busy), 1, "R8", "busy mid-line");
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R1");
    rst = 1'b0;
    @(negedge clk);
    checkIdle("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, queue depth %0d expected 0", q.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule